// File: doc/BRIEF.md
# Frame Permanence Buffer

This block holds synchronization control frames between the semantic filter and the synchronization state machine. Each incoming frame carries two values: the local time at which it was received, and the delay that the network has already added to it on the way. The block keeps the frame until the frame's total age reaches one fixed, configured maximum. That maximum is twice the worst-case transmission delay plus the delay of the compressing relay. At that moment, the permanence point, the frame is handed on. Every frame therefore reaches the state machine as if it had crossed the network with the worst-case delay, and almost all network jitter is removed from the timing of control frames.

There is one slot for each synchronization master that can send frames. The release time is computed when the frame arrives: receive time plus the configured maximum, minus the delay the frame has already recorded. A slot is released at the first clock edge at which the local time has reached that value. Frames therefore leave in order of permanence time, not in order of arrival. At most one frame leaves per cycle. If frames become due at the same edge, the lowest slot index goes first. A frame whose recorded delay already exceeds the maximum leaves at once and is marked as late. A frame that arrives when every slot is full is discarded and counted.

Top module: `permanence_buffer`

## Requirements
- R1: After reset, `out_valid` is 0, `drop_count` is 0 and every slot is empty.
- R2: A stored frame's release time is `(in_rx_time + MAX_TC - in_tc) mod 2^TW`. It is reported on `out_perm_time` when the frame is released.
- R3: A frame is never released before its release time. It is released at the first clock edge at which `cur_time - release_time`, read as a TW-bit signed value, is zero or more. `out_valid` is 1 during the cycle after that edge.
- R4: A frame with `in_tc > MAX_TC` is released at the first edge after it was stored, whatever `cur_time` is, with `out_late` = 1. A frame with `in_tc == MAX_TC` is not late: `out_late` = 0.
- R5: When several slots are due at one edge, the slot with the lowest index is released. Each of the others is released at a later edge, one per edge.
- R6: Frames leave in order of release time. A frame that arrived later but has a larger `in_tc` can leave before a frame that arrived earlier.
- R7: A frame offered while all SLOTS slots are occupied at that edge is discarded, and `drop_count` increases by 1 (modulo 2^CNTW). `drop_count` changes on no other edge.
- R8: An accepted frame goes into the lowest-index free slot. A slot freed by a release at some edge can be filled from the next edge onward. `out_slot` gives the index of the released slot.
- R9: `out_data` and `out_tc` return the values stored with the frame, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_time | input | TW | Local clock reading |
| in_valid | input | 1 | A frame from the filter is offered |
| in_rx_time | input | TW | Local time at which the frame was received |
| in_tc | input | TW | Delay the network has recorded in the frame |
| in_data | input | PW | Frame contents passed through |
| out_valid | output | 1 | A frame is released this cycle |
| out_slot | output | IDXW | Index of the slot that was released |
| out_data | output | PW | Contents of the released frame |
| out_tc | output | TW | Recorded delay of the released frame |
| out_perm_time | output | TW | Computed release time of the frame |
| out_late | output | 1 | The frame arrived with a recorded delay above the maximum |
| drop_count | output | CNTW | Frames discarded because all slots were full |

## Verification
A wrong release time or a wrong due check shows at the ports as `out_valid` rising one or more cycles away from the cycle the bench predicted. The mismatch appears as soon as the first affected frame falls due, at most MAX_TC cycles after it was received. Faulty slot bookkeeping shows within a few frames: a wrong `out_slot` or `out_data`, a frame released twice or never, or `drop_count` moving while a slot is still free. The bench runs a cycle-accurate model built from the requirements, so any such slip is reported in the cycle where it first shows at the outputs.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

   typedef enum logic {
      ST_EMPTY = 1'b0,
      ST_HELD  = 1'b1
   } slot_state_e;

   function automatic logic reached(input logic sign_of_diff);
      return !sign_of_diff;
   endfunction

endpackage

// File: rtl/fpb_release_calc.sv
module fpb_release_calc #(
   parameter int TW     = 16,
   parameter int MAX_TC = 100
) (
   input  logic [TW-1:0] rx_time,
   input  logic [TW-1:0] tc_value,
   output logic [TW-1:0] rel_time,
   output logic          late
);

   localparam logic [TW-1:0] MAX_W = TW'(MAX_TC);

   generate
      if (TW < 2) begin : g_bad_tw
         $error("fpb_release_calc: TW must be at least 2");
      end
      if (MAX_TC < 0 || MAX_TC >= (2 ** (TW - 1))) begin : g_bad_max
         $error("fpb_release_calc: MAX_TC must fit in half the time range");
      end
   endgenerate

   always_comb begin
      rel_time = rx_time + MAX_W - tc_value;
      late     = (tc_value > MAX_W);
   end

endmodule

// File: rtl/fpb_pick.sv
module fpb_pick #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic          any,
   output logic [IW-1:0] idx
);

   generate
      if (N < 1) begin : g_bad_n
         $error("fpb_pick: N must be at least 1");
      end

      if (N == 1) begin : g_single
         always_comb begin
            grant = req;
            any   = req[0];
            idx   = '0;
         end
      end else begin : g_multi
         always_comb begin
            logic found;
            found = 1'b0;
            grant = '0;
            idx   = '0;
            for (int k = 0; k < N; k++) begin
               if (req[k] && !found) begin
                  found    = 1'b1;
                  grant[k] = 1'b1;
                  idx      = IW'(k);
               end
            end
            any = found;
         end
      end

      for (genvar j = 0; j < N; j++) begin : g_chk
         AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
            grant[j] |-> (req[j] && ((req & ~({N{1'b1}} << j)) == '0))); // R5
      end
   endgenerate

   AST_PICK_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (any && grant != '0)); // R5

endmodule

// File: rtl/fpb_slot.sv
module fpb_slot
   import fpb_pkg::*;
#(
   parameter int TW = 16,
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] cur_time,
   input  logic          load,
   input  logic          clear,
   input  logic [TW-1:0] ld_rel,
   input  logic [TW-1:0] ld_tc,
   input  logic [PW-1:0] ld_data,
   input  logic          ld_late,
   output logic          held,
   output logic          due,
   output logic [TW-1:0] q_rel,
   output logic [TW-1:0] q_tc,
   output logic [PW-1:0] q_data,
   output logic          q_late
);

   slot_state_e   state;
   logic [TW-1:0] diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_EMPTY;
         q_rel  <= '0;
         q_tc   <= '0;
         q_data <= '0;
         q_late <= 1'b0;
      end else begin
         if (load) begin
            state  <= ST_HELD;
            q_rel  <= ld_rel;
            q_tc   <= ld_tc;
            q_data <= ld_data;
            q_late <= ld_late;
         end else if (clear) begin
            state  <= ST_EMPTY;
         end
      end
   end

   always_comb begin
      held = (state == ST_HELD);
      diff = cur_time - q_rel;
      due  = held && (q_late || reached(diff[TW-1]));
   end

   AST_SLOT_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (state == ST_EMPTY)); // R8

   AST_SLOT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HELD && !clear) |=> (state == ST_HELD)); // R8

   AST_SLOT_CLEAR_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      clear |-> due); // R3

   AST_SLOT_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !load) |=> (state == ST_EMPTY)); // R5

endmodule

// File: rtl/permanence_buffer.sv
module permanence_buffer #(
   parameter int SLOTS  = 4,
   parameter int TW     = 16,
   parameter int PW     = 8,
   parameter int MAX_TC = 100,
   parameter int CNTW   = 8,
   parameter int IDXW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TW-1:0]   cur_time,
   input  logic            in_valid,
   input  logic [TW-1:0]   in_rx_time,
   input  logic [TW-1:0]   in_tc,
   input  logic [PW-1:0]   in_data,
   output logic            out_valid,
   output logic [IDXW-1:0] out_slot,
   output logic [PW-1:0]   out_data,
   output logic [TW-1:0]   out_tc,
   output logic [TW-1:0]   out_perm_time,
   output logic            out_late,
   output logic [CNTW-1:0] drop_count
);

   localparam logic [TW-1:0] MAX_W = TW'(MAX_TC);

   generate
      if (SLOTS < 1) begin : g_bad_slots
         $error("permanence_buffer: SLOTS must be at least 1");
      end
      if (CNTW < 1) begin : g_bad_cnt
         $error("permanence_buffer: CNTW must be at least 1");
      end
      if (PW < 1) begin : g_bad_pw
         $error("permanence_buffer: PW must be at least 1");
      end
   endgenerate

   // release time of the frame offered this cycle
   logic [TW-1:0] new_rel;
   logic          new_late;

   fpb_release_calc #(.TW(TW), .MAX_TC(MAX_TC)) u_calc (
      .rx_time  (in_rx_time),
      .tc_value (in_tc),
      .rel_time (new_rel),
      .late     (new_late)
   );

   // slot array
   logic [SLOTS-1:0] held;
   logic [SLOTS-1:0] due;
   logic [SLOTS-1:0] load;
   logic [SLOTS-1:0] clear;
   logic [TW-1:0]    s_rel  [SLOTS];
   logic [TW-1:0]    s_tc   [SLOTS];
   logic [PW-1:0]    s_data [SLOTS];
   logic [SLOTS-1:0] s_late;

   generate
      for (genvar i = 0; i < SLOTS; i++) begin : g_slot
         fpb_slot #(.TW(TW), .PW(PW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_time (cur_time),
            .load     (load[i]),
            .clear    (clear[i]),
            .ld_rel   (new_rel),
            .ld_tc    (in_tc),
            .ld_data  (in_data),
            .ld_late  (new_late),
            .held     (held[i]),
            .due      (due[i]),
            .q_rel    (s_rel[i]),
            .q_tc     (s_tc[i]),
            .q_data   (s_data[i]),
            .q_late   (s_late[i])
         );
      end
   endgenerate

   // allocation of a free slot: lowest index wins
   logic [SLOTS-1:0] alloc_grant;
   logic             alloc_any;
   logic [IDXW-1:0]  alloc_idx;

   fpb_pick #(.N(SLOTS), .IW(IDXW)) u_alloc (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (~held),
      .grant (alloc_grant),
      .any   (alloc_any),
      .idx   (alloc_idx)
   );

   // release of a due slot: lowest index wins
   logic [SLOTS-1:0] rel_grant;
   logic             rel_any;
   logic [IDXW-1:0]  rel_idx;

   fpb_pick #(.N(SLOTS), .IW(IDXW)) u_release (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (due),
      .grant (rel_grant),
      .any   (rel_any),
      .idx   (rel_idx)
   );

   logic drop;
   logic all_full;

   always_comb begin
      load     = in_valid ? alloc_grant : '0;
      clear    = rel_grant;
      all_full = &held;
      drop     = in_valid && !alloc_any;
   end

   // one-hot mux of the released slot's contents
   logic [TW-1:0] sel_rel;
   logic [TW-1:0] sel_tc;
   logic [PW-1:0] sel_data;
   logic          sel_late;

   always_comb begin
      sel_rel  = '0;
      sel_tc   = '0;
      sel_data = '0;
      sel_late = 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
         if (rel_grant[i]) begin
            sel_rel  = sel_rel  | s_rel[i];
            sel_tc   = sel_tc   | s_tc[i];
            sel_data = sel_data | s_data[i];
            sel_late = sel_late | s_late[i];
         end
      end
   end

   // output register and drop counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_slot      <= '0;
         out_data      <= '0;
         out_tc        <= '0;
         out_perm_time <= '0;
         out_late      <= 1'b0;
         drop_count    <= '0;
      end else begin
         out_valid <= rel_any;
         if (rel_any) begin
            out_slot      <= rel_idx;
            out_data      <= sel_data;
            out_tc        <= sel_tc;
            out_perm_time <= sel_rel;
            out_late      <= sel_late;
         end
         if (drop) begin
            drop_count <= drop_count + 1'b1;
         end
      end
   end

   logic [TW-1:0] prev_time;
   logic [TW-1:0] age_at_release;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_time <= '0;
      else        prev_time <= cur_time;
   end

   always_comb age_at_release = prev_time - out_perm_time;

   AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_late) |-> !age_at_release[TW-1]); // R3

   AST_LATE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_late) |-> (out_tc > MAX_W)); // R4

   AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_count != $past(drop_count)) |-> ($past(in_valid) && $past(all_full))); // R7

   AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && all_full) |=> (drop_count == $past(drop_count) + 1'b1)); // R7

   AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !all_full) |-> ($countones(load) == 1)); // R8

endmodule

// File: tb/tb_permanence_buffer.sv
`timescale 1ns/1ps
module tb_permanence_buffer;

   localparam int SLOTS = 4;
   localparam int TW    = 16;
   localparam int PW    = 8;
   localparam int MAXD  = 100;
   localparam int CNTW  = 8;
   localparam int IDXW  = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [TW-1:0]   cur_time = '0;
   logic            in_valid = 1'b0;
   logic [TW-1:0]   in_rx_time = '0;
   logic [TW-1:0]   in_tc = '0;
   logic [PW-1:0]   in_data = '0;
   logic            out_valid;
   logic [IDXW-1:0] out_slot;
   logic [PW-1:0]   out_data;
   logic [TW-1:0]   out_tc;
   logic [TW-1:0]   out_perm_time;
   logic            out_late;
   logic [CNTW-1:0] drop_count;

   always #2.5 clk = ~clk;

   permanence_buffer #(
      .SLOTS(SLOTS), .TW(TW), .PW(PW), .MAX_TC(MAXD), .CNTW(CNTW), .IDXW(IDXW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cur_time(cur_time),
      .in_valid(in_valid), .in_rx_time(in_rx_time), .in_tc(in_tc), .in_data(in_data),
      .out_valid(out_valid), .out_slot(out_slot), .out_data(out_data), .out_tc(out_tc),
      .out_perm_time(out_perm_time), .out_late(out_late), .drop_count(drop_count)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   string cur_req  = "R1";

   // reference model state
   bit              m_v    [SLOTS];
   logic [TW-1:0]   m_rel  [SLOTS];
   logic [TW-1:0]   m_tc   [SLOTS];
   logic [PW-1:0]   m_data [SLOTS];
   bit              m_late [SLOTS];
   bit              e_valid = 1'b0;
   logic [IDXW-1:0] e_slot;
   logic [PW-1:0]   e_data;
   logic [TW-1:0]   e_tc;
   logic [TW-1:0]   e_perm;
   bit              e_late;
   logic [CNTW-1:0] e_drop = '0;

   function automatic logic [TW-1:0] f_rel(input logic [TW-1:0] rx, input logic [TW-1:0] tc);
      return rx + TW'(MAXD) - tc;
   endfunction

   function automatic bit f_late(input logic [TW-1:0] tc);
      return tc > TW'(MAXD);
   endfunction

   function automatic bit f_due(input int i, input logic [TW-1:0] now);
      logic [TW-1:0] d;
      d = now - m_rel[i];
      return m_v[i] && (m_late[i] || !d[TW-1]);
   endfunction

   task automatic fail_line(input string what, input longint act, input longint exp);
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
   endtask

   task automatic check_outputs();
      n_checks++;
      if (out_valid !== e_valid) fail_line("out_valid", out_valid, e_valid);
      n_checks++;
      if (drop_count !== e_drop) fail_line("drop_count", drop_count, e_drop);
      if (e_valid && out_valid) begin
         n_checks++;
         if (out_slot !== e_slot) fail_line("out_slot", out_slot, e_slot);
         if (out_data !== e_data) fail_line("out_data", out_data, e_data);
         if (out_tc !== e_tc) fail_line("out_tc", out_tc, e_tc);
         if (out_perm_time !== e_perm) fail_line("out_perm_time", out_perm_time, e_perm);
         if (out_late !== e_late) fail_line("out_late", out_late, e_late);
      end
   endtask

   // next edge of the model, using inputs now applied
   task automatic model_step();
      bit old_v [SLOTS];
      bit got;
      for (int i = 0; i < SLOTS; i++) old_v[i] = m_v[i];
      got = 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
         if (!got && f_due(i, cur_time)) begin
            got    = 1'b1;
            e_slot = IDXW'(i);
            e_data = m_data[i];
            e_tc   = m_tc[i];
            e_perm = m_rel[i];
            e_late = m_late[i];
            m_v[i] = 1'b0;
         end
      end
      e_valid = got;
      if (in_valid) begin
         got = 1'b0;
         for (int i = 0; i < SLOTS; i++) begin
            if (!got && !old_v[i]) begin
               got       = 1'b1;
               m_v[i]    = 1'b1;
               m_rel[i]  = f_rel(in_rx_time, in_tc);
               m_tc[i]   = in_tc;
               m_data[i] = in_data;
               m_late[i] = f_late(in_tc);
            end
         end
         if (!got) e_drop = e_drop + 1'b1;
      end
   endtask

   task automatic tick(input bit v, input int back, input int tc, input int d);
      @(negedge clk);
      check_outputs();
      cur_time   = cur_time + 1'b1;
      in_valid   = v;
      in_rx_time = cur_time - TW'(back);
      in_tc      = TW'(tc);
      in_data    = PW'(d);
      model_step();
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) tick(1'b0, 0, 0, 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < SLOTS; i++) m_v[i] = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cur_req = "R1";
      n_checks++;
      if (out_valid !== 1'b0) fail_line("out_valid after reset", out_valid, 0);
      n_checks++;
      if (drop_count !== '0) fail_line("drop_count after reset", drop_count, 0);
      idle(3);

      // R2 and R3: single frame held until rx + MAX - tc
      cur_req = "R2";
      tick(1'b1, 5, 30, 8'h11);
      cur_req = "R3";
      idle(80);

      // R4: late frame and frame exactly at the maximum
      cur_req = "R4";
      tick(1'b1, 0, MAXD + 50, 8'h22);
      idle(3);
      tick(1'b1, 0, MAXD, 8'h23);
      idle(3);
      tick(1'b1, 3, MAXD, 8'h24);
      tick(1'b1, 0, MAXD + 1, 8'h25);
      idle(4);

      // R5: two frames due at the same edge
      cur_req = "R5";
      tick(1'b1, 0, 10, 8'h31);
      tick(1'b1, 0, 11, 8'h32);
      idle(95);

      // R6: later frame with larger delay leaves first
      cur_req = "R6";
      tick(1'b1, 0, 0, 8'h41);
      tick(1'b1, 0, 95, 8'h42);
      idle(105);

      // R7: overflow when all slots are occupied
      cur_req = "R7";
      for (int k = 0; k < SLOTS; k++) tick(1'b1, 0, k, 8'h50 + k);
      tick(1'b1, 0, 0, 8'h5F);
      tick(1'b1, 0, 0, 8'h5E);

      // R8: freed slot reused once a release happens
      cur_req = "R8";
      idle(95);
      tick(1'b1, 0, 60, 8'h61);
      idle(60);

      // R9: random traffic, contents carried through
      cur_req = "R9";
      for (int k = 0; k < 2500; k++) begin
         int r;
         r = int'($urandom % 4);
         if (r == 0) tick(1'b1, int'($urandom % 8), int'($urandom % (MAXD + 30)), int'($urandom % 256));
         else        tick(1'b0, 0, 0, 0);
      end
      idle(150);

      done = 1'b1;
      finish_run();
   end

endmodule